// File: doc/BRIEF.md
# Microcontroller Clock and Reset Supervisor

This block supplies a companion microcontroller with its clock and its reset. The clock output is the crystal clock passed through a divider whose ratio is chosen by a 2-bit code held in a small register. After a wake-up event the block waits for the oscillator to settle and then holds the microcontroller in reset for a further fixed delay before releasing it. During normal running a watchdog timer expects bus traffic. If the traffic stops for too long, the watchdog pulses the microcontroller reset.

Wake-up needs both supply-good flags plus at least one wake source: line, ringing or external supply. The block powers down when the shutdown bit is set or a supply flag drops. A dropped supply also raises a register-clear output that wipes the local control registers, including the divider code. A watchdog reset and a shutdown leave those registers alone. All delays are counted in crystal clock cycles and set by parameters.

Top module: `mcu_clk_rst_sup`

## Requirements
- R1: The divider code selects the output ratio: code 0 gives the crystal clock itself, code 1 divides by 8, code 2 by 16 and code 3 by 32. Every ratio above 1 has equal high and low phases.
- R2: A code written with `sel_wr` is stored. It takes effect only after the output period in progress has completed. With codes 1 to 3, no high or low phase of the output is shorter than 4 crystal cycles.
- R3: `reg_clr` is high during `rst` and whenever either supply flag is low, within 3 cycles of the flag falling. While `reg_clr` is high the stored divider code returns to 0, and it stays 0 until rewritten.
- R4: The microcontroller stays in reset, with no wake-up, unless both supply flags are high, at least one of `line_on`, `ring_on` or `ext_on` is high, and `shutdown` is low.
- R5: `mcu_clk` is held low from power-down until the oscillator start-up interval (`OSC_CYC` cycles) after wake-up has elapsed. It runs from then on.
- R6: `mcu_rst` falls between `OSC_CYC+HOLD_CYC` and `OSC_CYC+HOLD_CYC+4` cycles after a wake source rises at the pins, with the supplies already good.
- R7: While running, each `bus_act` pulse restarts the watchdog. Once `WDOG_CYC` cycles pass with no pulse, `mcu_rst` goes high for `HOLD_CYC` cycles (±1) and is then released.
- R8: A watchdog reset does not raise `reg_clr` and does not change the stored divider code.
- R9: Setting `shutdown` raises `mcu_rst` within 2 cycles and stops `mcu_clk`, but leaves `reg_clr` low and the divider code intact. Clearing it starts a fresh wake-up.
- R10: A supply flag falling in any state raises `mcu_rst` within 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal oscillator clock |
| rst | input | 1 | Synchronous active-high chip reset |
| vmp_ok | input | 1 | Microcontroller supply above its good level (asynchronous) |
| vb_ok | input | 1 | Speech supply above its good level (asynchronous) |
| line_on | input | 1 | Line voltage present (asynchronous) |
| ring_on | input | 1 | Ringing present (asynchronous) |
| ext_on | input | 1 | External supply present (asynchronous) |
| shutdown | input | 1 | Shutdown control bit, synchronous |
| bus_act | input | 1 | One-cycle pulse per serial bus transfer |
| sel_wr | input | 1 | Write strobe for the divider code |
| sel_code | input | 2 | Divider code to store |
| mcu_clk | output | 1 | Clock to the microcontroller |
| mcu_rst | output | 1 | Active-high microcontroller reset |
| reg_clr | output | 1 | Active-high clear for local control registers |

## Verification
The assertions assume that `bus_act`, `shutdown`, `sel_wr` and `sel_code` are synchronous to the crystal clock and that `bus_act` arrives as single-cycle pulses. Only the supply and wake flags may change at any time, because they pass through the synchronisers first. The stimulus drives every input a quarter period after the rising edge and samples outputs at the same point. Where the output phase matters, it also samples three quarters into the cycle. The supply flags are raised and allowed to settle before any wake source is raised, so the wake-up timing check starts from a known synchroniser state.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_OSC,
        ST_HOLD,
        ST_RUN,
        ST_WDOG
    } sup_state_t;

    typedef logic [1:0] div_code_t;

    localparam int RATIO_W = 6;
    localparam int PCNT_W  = 5;

    function automatic logic [RATIO_W-1:0] div_ratio(input div_code_t c);
        case (c)
            2'd0:    return 6'd1;
            2'd1:    return 6'd8;
            2'd2:    return 6'd16;
            default: return 6'd32;
        endcase
    endfunction

endpackage

// File: rtl/sync_ff.sv
module sync_ff #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/clk_ratio_div.sv
module clk_ratio_div
    import mcs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  div_code_t code_in,
    output logic      bypass,
    output logic      div_q
);
    div_code_t            act_code;
    logic [PCNT_W-1:0]    pcnt;
    logic [PCNT_W-1:0]    nxt;
    logic [RATIO_W-1:0]   ratio;
    logic [RATIO_W-1:0]   new_ratio;
    logic [RATIO_W-1:0]   load_ratio;
    logic                 wrap;

    always_comb begin
        ratio      = div_ratio(act_code);
        new_ratio  = div_ratio(code_in);
        load_ratio = new_ratio - 6'd1;
        wrap       = ({1'b0, pcnt} == ratio - 6'd1);
        nxt        = wrap ? '0 : pcnt + 1'b1;
    end

    // Pending code is loaded only at the period boundary, so phases never shrink
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            act_code <= code_in;
            pcnt     <= load_ratio[PCNT_W-1:0];
            div_q    <= 1'b0;
        end else begin
            pcnt <= nxt;
            if (wrap) begin
                act_code <= code_in;
                div_q    <= (new_ratio > 6'd1);
            end else begin
                div_q    <= ({1'b0, nxt} < (ratio >> 1));
            end
        end
    end

    assign bypass = (act_code == 2'd0);

    // Phase length tracker for the no-runt check
    logic [5:0] run_len;
    logic       q_d;
    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
            q_d     <= 1'b0;
        end else begin
            q_d     <= div_q;
            run_len <= (div_q != q_d) ? 6'd0 : ((run_len == 6'd63) ? run_len : run_len + 6'd1);
        end
    end

    AST_NO_RUNT: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && div_q != q_d && act_code != 2'd0 && $past(act_code) != 2'd0)
            |-> run_len >= 6'd3)
        else $error("runt phase on divided clock"); // R2

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !en |=> !div_q)
        else $error("divided clock active while disabled"); // R5
endmodule

// File: rtl/rst_seq.sv
module rst_seq
    import mcs_pkg::*;
#(
    parameter int OSC_CYC  = 3580,
    parameter int HOLD_CYC = 16110,
    parameter int WDOG_CYC = 3580000
) (
    input  logic clk,
    input  logic rst,
    input  logic sup_ok,
    input  logic wake,
    input  logic sd,
    input  logic bus_act,
    output logic mcu_rst,
    output logic clk_en
);
    localparam int MAX_AB = (OSC_CYC > HOLD_CYC) ? OSC_CYC : HOLD_CYC;
    localparam int MAXC   = (WDOG_CYC > MAX_AB) ? WDOG_CYC : MAX_AB;
    localparam int CW     = $clog2(MAXC + 1);

    sup_state_t    state;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !sup_ok) begin
            state <= ST_OFF;
            cnt   <= '0;
        end else if (sd && state != ST_OFF) begin
            state <= ST_OFF;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_OFF: begin
                    cnt <= '0;
                    if (wake && !sd) state <= ST_OSC;
                end
                ST_OSC: begin
                    if (cnt == CW'(OSC_CYC - 1)) begin
                        state <= ST_HOLD;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                ST_HOLD, ST_WDOG: begin
                    if (cnt == CW'(HOLD_CYC - 1)) begin
                        state <= ST_RUN;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                ST_RUN: begin
                    if (bus_act) cnt <= '0;
                    else if (cnt == CW'(WDOG_CYC - 1)) begin
                        state <= ST_WDOG;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                default: begin
                    state <= ST_OFF;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assign mcu_rst = (state != ST_RUN);
    assign clk_en  = (state == ST_HOLD) || (state == ST_RUN) || (state == ST_WDOG);

    AST_LOWV_OFF: assert property (@(posedge clk) disable iff (rst)
        !sup_ok |=> state == ST_OFF)
        else $error("no power-down on low supply"); // R10

    AST_WAKE_GATED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OFF && !(wake && !sd)) |=> state == ST_OFF)
        else $error("wake-up without a valid source"); // R4

    AST_KICK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && bus_act && sup_ok && !sd) |=> state == ST_RUN)
        else $error("watchdog fired despite bus activity"); // R7

    AST_SD_OFF: assert property (@(posedge clk) disable iff (rst)
        (sd && state != ST_OFF) |=> state == ST_OFF)
        else $error("shutdown ignored"); // R9
endmodule

// File: rtl/mcu_clk_rst_sup.sv
module mcu_clk_rst_sup
    import mcs_pkg::*;
#(
    parameter int OSC_CYC  = 3580,
    parameter int HOLD_CYC = 16110,
    parameter int WDOG_CYC = 3580000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       vmp_ok,
    input  logic       vb_ok,
    input  logic       line_on,
    input  logic       ring_on,
    input  logic       ext_on,
    input  logic       shutdown,
    input  logic       bus_act,
    input  logic       sel_wr,
    input  logic [1:0] sel_code,
    output logic       mcu_clk,
    output logic       mcu_rst,
    output logic       reg_clr
);
    localparam int NFLAG = 5;

    logic [NFLAG-1:0] flags_s;
    logic             sup_ok_s;
    logic             wake_s;
    div_code_t        sel_q;
    logic             clk_en;
    logic             bypass;
    logic             div_q;

    sync_ff #(.W(NFLAG), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({vmp_ok, vb_ok, line_on, ring_on, ext_on}),
        .q   (flags_s)
    );

    assign sup_ok_s = flags_s[4] & flags_s[3];
    assign wake_s   = |flags_s[2:0];
    assign reg_clr  = rst | ~sup_ok_s;

    always_ff @(posedge clk) begin
        if (reg_clr)     sel_q <= 2'd0;
        else if (sel_wr) sel_q <= sel_code;
    end

    rst_seq #(
        .OSC_CYC  (OSC_CYC),
        .HOLD_CYC (HOLD_CYC),
        .WDOG_CYC (WDOG_CYC)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .sup_ok  (sup_ok_s),
        .wake    (wake_s),
        .sd      (shutdown),
        .bus_act (bus_act),
        .mcu_rst (mcu_rst),
        .clk_en  (clk_en)
    );

    clk_ratio_div u_div (
        .clk     (clk),
        .rst     (rst),
        .en      (clk_en),
        .code_in (sel_q),
        .bypass  (bypass),
        .div_q   (div_q)
    );

    assign mcu_clk = clk_en & (bypass ? clk : div_q);

    AST_SEL_CLEARED: assert property (@(posedge clk) disable iff (rst)
        reg_clr |=> sel_q == 2'd0)
        else $error("divider code survived register clear"); // R3

    AST_SEL_KEPT: assert property (@(posedge clk) disable iff (rst)
        (!reg_clr && !sel_wr) |=> $stable(sel_q))
        else $error("divider code changed without a write"); // R8
endmodule

// File: tb/sim_mcu_clk_rst_sup.sv
module sim_mcu_clk_rst_sup;
    localparam int OSC  = 40;
    localparam int HOLD = 90;
    localparam int WD   = 400;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst = 1'b1;
    logic       vmp_ok = 1'b0, vb_ok = 1'b0;
    logic       line_on = 1'b0, ring_on = 1'b0, ext_on = 1'b0;
    logic       shutdown = 1'b0, bus_act = 1'b0, sel_wr = 1'b0;
    logic [1:0] sel_code = 2'd0;
    logic       mcu_clk, mcu_rst, reg_clr;

    int n_cmp = 0, n_bad = 0;
    int cyc = 0, last_kick = 0, kick_per = 150;
    bit kick_en = 1'b0;

    mcu_clk_rst_sup #(.OSC_CYC(OSC), .HOLD_CYC(HOLD), .WDOG_CYC(WD)) u0 (
        .clk(clk), .rst(rst), .vmp_ok(vmp_ok), .vb_ok(vb_ok),
        .line_on(line_on), .ring_on(ring_on), .ext_on(ext_on),
        .shutdown(shutdown), .bus_act(bus_act), .sel_wr(sel_wr),
        .sel_code(sel_code), .mcu_clk(mcu_clk), .mcu_rst(mcu_rst),
        .reg_clr(reg_clr)
    );

    // bus traffic generator
    initial begin
        forever begin
            @(posedge clk); #2;
            cyc++;
            if (kick_en && (cyc - last_kick) >= kick_per) begin
                bus_act   = 1'b1;
                last_kick = cyc;
            end else bus_act = 1'b0;
        end
    end

    task automatic step(input int n = 1);
        repeat (n) begin @(posedge clk); #5; end
    endtask

    task automatic check(input string req, input int act, input int lo, input int hi);
        n_cmp++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic write_sel(input logic [1:0] c);
        sel_code = c; sel_wr = 1'b1; step(1); sel_wr = 1'b0;
    endtask

    task automatic measure(output int hi, output int lo);
        logic prev;
        int g;
        prev = mcu_clk; g = 0;
        while (g < 100) begin
            step(1); g++;
            if (mcu_clk && !prev) break;
            prev = mcu_clk;
        end
        hi = 0; while (mcu_clk && hi < 100) begin hi++; step(1); end
        lo = 0; while (!mcu_clk && lo < 100) begin lo++; step(1); end
    endtask

    task automatic check_ratio(input string req, input int n);
        int hi, lo;
        if (n == 1) begin
            repeat (3) begin
                @(posedge clk); #5; check({req, " bypass high"}, mcu_clk, 1, 1);
                #10;                check({req, " bypass low"}, mcu_clk, 0, 0);
            end
            step(1);
        end else begin
            measure(hi, lo);
            check({req, " high phase"}, hi, n/2, n/2);
            check({req, " low phase"}, lo, n/2, n/2);
        end
    endtask

    task automatic wait_release(output int n);
        n = 0;
        while (mcu_rst && n < 2000) begin step(1); n++; end
    endtask

    task automatic t_reset();
        rst = 1'b1; step(3); rst = 1'b0; step(1);
        check("R3 reg_clr after reset", reg_clr, 1, 1);
        check("R4 mcu_rst after reset", mcu_rst, 1, 1);
        check("R5 mcu_clk after reset", mcu_clk, 0, 0);
    endtask

    task automatic t_no_wake();
        vmp_ok = 1'b1; vb_ok = 1'b1; step(5);
        check("R3 reg_clr with supplies good", reg_clr, 0, 0);
        step(300);
        check("R4 no source keeps reset", mcu_rst, 1, 1);
        shutdown = 1'b1; line_on = 1'b1; step(300);
        check("R4 shutdown blocks wake", mcu_rst, 1, 1);
        line_on = 1'b0; shutdown = 1'b0; vb_ok = 1'b0; ext_on = 1'b1; step(300);
        check("R4 low supply blocks wake", mcu_rst, 1, 1);
        ext_on = 1'b0; vb_ok = 1'b1; step(5);
    endtask

    task automatic t_power_up();
        int n;
        kick_en = 1'b1;
        line_on = 1'b1;
        n = 0;
        while (mcu_rst && n < 2000) begin
            step(1); n++;
            if (n == 10) begin
                check("R5 clock held in start-up (a)", mcu_clk, 0, 0);
                #10; check("R5 clock held in start-up (b)", mcu_clk, 0, 0);
                #10; #0;
                @(posedge clk); #5; n++;
            end
            if (n == OSC + 8) check("R5 clock running after start-up", mcu_clk, 1, 1);
        end
        check("R6 release delay", n, OSC + HOLD, OSC + HOLD + 4);
        check("R3 reg_clr low while running", reg_clr, 0, 0);
    endtask

    task automatic t_ratios();
        write_sel(2'd1); step(80); check_ratio("R1 code1", 8);
        write_sel(2'd2); step(80); check_ratio("R1 code2", 16);
        write_sel(2'd3); step(80); check_ratio("R1 code3", 32);
        write_sel(2'd0); step(80); check_ratio("R1 code0", 1);
    endtask

    task automatic t_switch();
        int hi, lo, h, l;
        write_sel(2'd3); step(80);
        measure(hi, lo);
        h = 1;
        repeat (2) begin step(1); if (mcu_clk) h++; end
        sel_code = 2'd1; sel_wr = 1'b1; step(1); if (mcu_clk) h++; sel_wr = 1'b0;
        while (mcu_clk && h < 100) begin step(1); if (mcu_clk) h++; end
        l = 0; while (!mcu_clk && l < 100) begin l++; step(1); end
        check("R2 old high phase completes", h, 16, 16);
        check("R2 old low phase completes", l, 16, 16);
        measure(hi, lo);
        check("R2 new high phase", hi, 4, 4);
        check("R2 new low phase", lo, 4, 4);
    endtask

    task automatic t_watchdog();
        int seen, n, w, clr;
        write_sel(2'd2);
        kick_per = WD / 2;
        seen = 0;
        repeat (4 * WD) begin step(1); if (mcu_rst) seen++; end
        check("R7 regular traffic keeps reset low", seen, 0, 0);
        kick_en = 1'b0;
        n = 0;
        while (!mcu_rst && n < 2 * WD) begin step(1); n++; end
        check("R7 watchdog timeout", cyc - last_kick, WD - 1, WD + 3);
        w = 0; clr = 0;
        while (mcu_rst && w < 4 * HOLD) begin
            if (reg_clr) clr++;
            w++; step(1);
        end
        kick_en = 1'b1; kick_per = 150;
        check("R7 watchdog pulse width", w, HOLD - 1, HOLD + 1);
        check("R8 no register clear on watchdog", clr, 0, 0);
        step(40);
        check_ratio("R8 code kept after watchdog", 16);
    endtask

    task automatic t_shutdown();
        int n;
        shutdown = 1'b1; step(2);
        check("R9 shutdown asserts reset", mcu_rst, 1, 1);
        check("R9 shutdown keeps reg_clr low", reg_clr, 0, 0);
        repeat (3) begin
            @(posedge clk); #5; check("R9 clock stopped (a)", mcu_clk, 0, 0);
            #10;                check("R9 clock stopped (b)", mcu_clk, 0, 0);
        end
        step(1);
        shutdown = 1'b0;
        wait_release(n);
        check("R9 rewake after shutdown", n, OSC + HOLD - 3, OSC + HOLD + 4);
        step(40);
        check_ratio("R9 code kept after shutdown", 16);
    endtask

    task automatic t_lowv();
        int n;
        vb_ok = 1'b0; step(4);
        check("R3 reg_clr on low supply", reg_clr, 1, 1);
        check("R10 reset on low supply", mcu_rst, 1, 1);
        line_on = 1'b0; vb_ok = 1'b1; step(5);
        ring_on = 1'b1;
        wait_release(n);
        check("R6 release delay via ringing", n, OSC + HOLD, OSC + HOLD + 4);
        step(40);
        check_ratio("R3 code back to 0 after clear", 1);
    endtask

    initial begin
        #(20 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not complete");
        summary();
        $finish;
    end

    initial begin
        step(1);
        t_reset();
        t_no_wake();
        t_power_up();
        t_ratios();
        t_switch();
        t_watchdog();
        t_shutdown();
        t_lowv();
        summary();
        $finish;
    end
endmodule